// File: doc/BRIEF.md
# Voltage Domain Spread Checker

This block judges a frame of per-domain voltage readings taken from a chain of series-stacked power domains. Each domain shares one regulated rail, and the stack divides the board input between the domains. A healthy stack therefore shows nearly equal domain voltages. A single bad domain disturbs the whole chain. The readings arrive as a stream of samples. Each sample carries a domain index and a millivolt value, and the stream is framed by start and last markers. The block stores the frame while it arrives and keeps a running sum, minimum and maximum.

After the last sample, a scan visits every domain once, one domain per cycle. It compares the domain with its neighbours and with the frame average. A domain that sits well below its neighbours is a partial short. A domain that sits well above the frame average is an open. A smaller deviation from the neighbours in either direction is a drift. When the scan ends, the block raises `done_o` and presents four results: the status of every domain, the lowest failing domain, a board-level pass, and the max-minus-min spread for logging. All three thresholds are millivolt inputs. The typical settings are ±50 mV tolerance, a 100 mV short margin and a 100 mV open margin. The domain count and the sample width are parameters.

Top module: `vds_spread_checker`

## Requirements
- R1: A sample is stored at the domain given by its index, so samples may arrive in any order. A sample with start set opens a new frame and is itself part of that frame. Outside a frame, a sample without start is ignored.
- R2: A domain gets status code 1 (short) when twice the neighbour average minus twice its own value exceeds twice `short_mv_i`. In other words, it sits more than `short_mv_i` below its neighbours.
- R3: A domain gets status code 2 (open) when its value exceeds the frame mean by more than `open_mv_i`. The mean is the frame sum divided by N_DOM, compared without rounding.
- R4: A domain whose deviation from its neighbour average exceeds `tol_mv_i` in either direction gets status code 3 (drift) if neither R2 nor R3 applies. A deviation exactly equal to a threshold does not trip it. Every other domain gets code 0 (ok).
- R5: Domain 0 is compared only with domain 1, and domain N_DOM-1 only with domain N_DOM-2. Every other domain uses the mean of both of its neighbours.
- R6: When several conditions hold, short takes priority over open, and open takes priority over drift.
- R7: While `done_o` is high, `board_pass_o` is 1 exactly when every domain status is 0. `board_pass_o` is never 1 while `done_o` is low.
- R8: While `done_o` is high and the board fails, `first_fail_o` holds the lowest index whose status is not 0.
- R9: While `done_o` is high, `spread_mv_o` holds the highest minus the lowest sample value of the frame.
- R10: `done_o` rises on the N_DOM-th rising clock edge after the edge that accepts the last sample. It stays high until a sample with start is accepted, and that sample clears it.
- R11: Samples and start markers that arrive during the scan are ignored. They change neither the result nor the scan timing.
- R12: After reset, `done_o`, `board_pass_o`, `first_fail_o`, `spread_mv_o` and every status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample present this cycle |
| sample_start_i | input | 1 | First sample of a frame |
| sample_last_i | input | 1 | Final sample of a frame |
| sample_idx_i | input | IDX_W | Domain index of the sample |
| sample_mv_i | input | MV_W | Domain voltage in mV |
| tol_mv_i | input | MV_W | Neighbour tolerance in mV |
| short_mv_i | input | MV_W | Short margin below neighbours in mV |
| open_mv_i | input | MV_W | Open margin above frame mean in mV |
| done_o | output | 1 | Classification complete |
| board_pass_o | output | 1 | All domains ok |
| first_fail_o | output | IDX_W | Lowest failing domain |
| spread_mv_o | output | MV_W | Max minus min of the frame |
| stat_o | output | 2*N_DOM | Status of domain i at bits 2i+1:2i |

## Verification
The assertions check the result-framing rules on every cycle:
- the pass flag only appears while done is high, and it agrees with an all-zero status vector;
- the reported first failure points at a non-ok status;
- done rises only out of a scan, and falls only on an accepted start;
- the frame sum stays frozen throughout the scan.

The per-domain classification depends on the actual voltage patterns, so only the bench's scenarios can show it. That covers both threshold boundaries, the end-domain neighbours, the priority between the classes, reverse-order delivery and the exact done latency.

// File: rtl/vds_pkg.sv
package vds_pkg;
  typedef enum logic [1:0] {
    DOM_OK    = 2'd0,
    DOM_SHORT = 2'd1,
    DOM_OPEN  = 2'd2,
    DOM_DRIFT = 2'd3
  } dom_stat_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAPT,
    ST_SCAN,
    ST_DONE
  } scan_st_e;
endpackage

// File: rtl/vds_capture.sv
module vds_capture #(
  parameter int N_DOM = 38,
  parameter int MV_W  = 12,
  localparam int IDX_W = $clog2(N_DOM),
  localparam int SUM_W = MV_W + IDX_W + 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           acc_i,
  input  logic                           start_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [MV_W-1:0]                mv_i,
  output logic [N_DOM-1:0][MV_W-1:0]     mv_o,
  output logic [SUM_W-1:0]               sum_o,
  output logic [MV_W-1:0]                min_o,
  output logic [MV_W-1:0]                max_o
);
  logic [N_DOM-1:0][MV_W-1:0] mem_q;
  logic [SUM_W-1:0]           sum_q;
  logic [MV_W-1:0]            min_q, max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      sum_q <= '0;
      min_q <= '0;
      max_q <= '0;
    end else if (acc_i) begin
      if (int'(idx_i) < N_DOM) mem_q[idx_i] <= mv_i;
      if (start_i) begin
        sum_q <= SUM_W'(mv_i);
        min_q <= mv_i;
        max_q <= mv_i;
      end else begin
        sum_q <= sum_q + SUM_W'(mv_i);
        if (mv_i < min_q) min_q <= mv_i;
        if (mv_i > max_q) max_q <= mv_i;
      end
    end
  end

  assign mv_o  = mem_q;
  assign sum_o = sum_q;
  assign min_o = min_q;
  assign max_o = max_q;
endmodule

// File: rtl/vds_classify.sv
module vds_classify
  import vds_pkg::*;
#(
  parameter int N_DOM = 38,
  parameter int MV_W  = 12,
  localparam int IDX_W = $clog2(N_DOM),
  localparam int SUM_W = MV_W + IDX_W + 1,
  localparam int W     = MV_W + IDX_W + 3
) (
  input  logic [MV_W-1:0]  self_i,
  input  logic [MV_W-1:0]  left_i,
  input  logic [MV_W-1:0]  right_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [MV_W-1:0]  tol_i,
  input  logic [MV_W-1:0]  short_i,
  input  logic [MV_W-1:0]  open_i,
  output dom_stat_e        stat_o
);
  // Compare doubled values against neighbour sums and N-scaled values
  // against the frame sum: no divider and no rounding.
  logic [W-1:0] nb2, self2, self_n, open_lim, tol2, short2;
  logic         is_short, is_open, is_drift;

  always_comb begin
    self2 = W'(self_i) << 1;
    if (first_i)     nb2 = W'(right_i) << 1;
    else if (last_i) nb2 = W'(left_i) << 1;
    else             nb2 = W'(left_i) + W'(right_i);
    self_n   = W'(self_i) * W'(N_DOM);
    open_lim = W'(sum_i) + W'(open_i) * W'(N_DOM);
    tol2     = W'(tol_i) << 1;
    short2   = W'(short_i) << 1;
    is_short = nb2 > self2 + short2;
    is_open  = self_n > open_lim;
    is_drift = (nb2 > self2 + tol2) || (self2 > nb2 + tol2);
    if (is_short)      stat_o = DOM_SHORT;
    else if (is_open)  stat_o = DOM_OPEN;
    else if (is_drift) stat_o = DOM_DRIFT;
    else               stat_o = DOM_OK;
  end
endmodule

// File: rtl/vds_scan.sv
module vds_scan
  import vds_pkg::*;
#(
  parameter int N_DOM = 38,
  parameter int MV_W  = 12,
  localparam int IDX_W = $clog2(N_DOM)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   start_i,
  input  logic                   last_i,
  input  dom_stat_e              stat_i,
  input  logic [MV_W-1:0]        spread_i,
  output logic                   acc_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   pass_o,
  output logic [IDX_W-1:0]       first_o,
  output logic [MV_W-1:0]        spread_o,
  output logic [2*N_DOM-1:0]     stat_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DOM - 1);

  scan_st_e                st_q;
  logic [IDX_W-1:0]        idx_q, first_q;
  logic                    fail_q;
  logic [MV_W-1:0]         spread_q;
  logic [N_DOM-1:0][1:0]   stat_q;

  assign acc_o = valid_i && (st_q != ST_SCAN) && (start_i || st_q == ST_CAPT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      first_q  <= '0;
      fail_q   <= 1'b0;
      spread_q <= '0;
      stat_q   <= '0;
    end else if (acc_o) begin
      if (start_i) begin
        stat_q   <= '0;
        fail_q   <= 1'b0;
        first_q  <= '0;
        spread_q <= '0;
      end
      st_q  <= last_i ? ST_SCAN : ST_CAPT;
      idx_q <= '0;
    end else if (st_q == ST_SCAN) begin
      stat_q[idx_q] <= stat_i;
      if (stat_i != DOM_OK && !fail_q) begin
        fail_q  <= 1'b1;
        first_q <= idx_q;
      end
      if (idx_q == LAST_IDX) begin
        st_q     <= ST_DONE;
        spread_q <= spread_i;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign idx_o    = idx_q;
  assign busy_o   = st_q == ST_SCAN;
  assign done_o   = st_q == ST_DONE;
  assign pass_o   = done_o && !fail_q;
  assign first_o  = first_q;
  assign spread_o = spread_q;
  assign stat_o   = stat_q;
endmodule

// File: rtl/vds_spread_checker.sv
module vds_spread_checker
  import vds_pkg::*;
#(
  parameter int N_DOM = 38,
  parameter int MV_W  = 12,
  localparam int IDX_W = $clog2(N_DOM),
  localparam int SUM_W = MV_W + IDX_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_valid_i,
  input  logic                 sample_start_i,
  input  logic                 sample_last_i,
  input  logic [IDX_W-1:0]     sample_idx_i,
  input  logic [MV_W-1:0]      sample_mv_i,
  input  logic [MV_W-1:0]      tol_mv_i,
  input  logic [MV_W-1:0]      short_mv_i,
  input  logic [MV_W-1:0]      open_mv_i,
  output logic                 done_o,
  output logic                 board_pass_o,
  output logic [IDX_W-1:0]     first_fail_o,
  output logic [MV_W-1:0]      spread_mv_o,
  output logic [2*N_DOM-1:0]   stat_o
);
  logic                        acc, scan_busy;
  logic [IDX_W-1:0]            scan_idx, left_idx, right_idx;
  logic [N_DOM-1:0][MV_W-1:0]  dom_mv;
  logic [SUM_W-1:0]            frame_sum;
  logic [MV_W-1:0]             frame_min, frame_max;
  dom_stat_e                   cur_stat;

  vds_capture #(.N_DOM(N_DOM), .MV_W(MV_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .start_i (sample_start_i),
    .idx_i   (sample_idx_i),
    .mv_i    (sample_mv_i),
    .mv_o    (dom_mv),
    .sum_o   (frame_sum),
    .min_o   (frame_min),
    .max_o   (frame_max)
  );

  always_comb begin
    left_idx  = (scan_idx == '0) ? '0 : scan_idx - 1'b1;
    right_idx = (int'(scan_idx) >= N_DOM - 1) ? scan_idx : scan_idx + 1'b1;
  end

  vds_classify #(.N_DOM(N_DOM), .MV_W(MV_W)) u_classify (
    .self_i  (dom_mv[scan_idx]),
    .left_i  (dom_mv[left_idx]),
    .right_i (dom_mv[right_idx]),
    .first_i (scan_idx == '0),
    .last_i  (int'(scan_idx) == N_DOM - 1),
    .sum_i   (frame_sum),
    .tol_i   (tol_mv_i),
    .short_i (short_mv_i),
    .open_i  (open_mv_i),
    .stat_o  (cur_stat)
  );

  vds_scan #(.N_DOM(N_DOM), .MV_W(MV_W)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (sample_valid_i),
    .start_i  (sample_start_i),
    .last_i   (sample_last_i),
    .stat_i   (cur_stat),
    .spread_i (frame_max - frame_min),
    .acc_o    (acc),
    .idx_o    (scan_idx),
    .busy_o   (scan_busy),
    .done_o   (done_o),
    .pass_o   (board_pass_o),
    .first_o  (first_fail_o),
    .spread_o (spread_mv_o),
    .stat_o   (stat_o)
  );
endmodule

// File: rtl/vds_chk.sv
module vds_chk #(
  parameter int N_DOM = 38,
  parameter int MV_W  = 12,
  localparam int IDX_W = $clog2(N_DOM),
  localparam int SUM_W = MV_W + IDX_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sample_valid_i,
  input logic               sample_start_i,
  input logic               done_o,
  input logic               board_pass_o,
  input logic [IDX_W-1:0]   first_fail_o,
  input logic [2*N_DOM-1:0] stat_o,
  input logic               busy_i,
  input logic [SUM_W-1:0]   sum_i
);
  // R7
  pass_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    board_pass_o |-> done_o);

  // R7
  pass_all_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && board_pass_o) |-> (stat_o == '0));

  // R8
  first_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !board_pass_o) |-> (stat_o[2*int'(first_fail_o) +: 2] != 2'b00));

  // R10
  done_from_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_i));

  // R10
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(sample_valid_i && sample_start_i));

  // R11
  scan_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(sum_i));
endmodule

bind vds_spread_checker vds_chk #(.N_DOM(N_DOM), .MV_W(MV_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .sample_start_i (sample_start_i),
  .done_o         (done_o),
  .board_pass_o   (board_pass_o),
  .first_fail_o   (first_fail_o),
  .stat_o         (stat_o),
  .busy_i         (scan_busy),
  .sum_i          (frame_sum)
);

// File: tb/vds_spread_checker_bench.sv
`timescale 1ns/1ps
module vds_spread_checker_bench;
  localparam int N  = 6;
  localparam int MW = 12;
  localparam int IW = 3;
  localparam int NF = 10;

  // frames: all-ok, short, open, end short, priority, tol edge, tol+1,
  // short edge, wider thresholds, reversed order
  localparam int VMV [NF][N] = '{
    '{360,360,360,360,360,360},
    '{360,360,240,360,360,360},
    '{360,360,360,560,360,360},
    '{250,360,360,360,360,360},
    '{10,10,10,10,800,600},
    '{360,360,410,360,360,360},
    '{360,360,411,360,360,360},
    '{360,360,260,360,360,360},
    '{360,360,240,360,360,360},
    '{360,360,360,560,360,360}};
  localparam int TOL [NF] = '{50,50,50,50,50,50,50,50,70,50};
  localparam int SHT [NF] = '{100,100,100,100,100,100,100,100,130,100};
  localparam int OPN [NF] = '{100,100,100,100,100,100,100,100,100,100};
  localparam int EXP [NF][N] = '{
    '{0,0,0,0,0,0},
    '{0,3,1,3,0,0},
    '{0,0,3,2,3,0},
    '{1,3,0,0,0,0},
    '{0,0,0,1,2,1},
    '{0,0,0,0,0,0},
    '{0,0,3,0,0,0},
    '{0,0,3,0,0,0},
    '{0,0,3,0,0,0},
    '{0,0,3,2,3,0}};
  localparam int EFIRST [NF] = '{0,1,2,0,3,0,2,2,2,2};
  localparam int EPASS  [NF] = '{1,0,0,0,0,1,0,0,0,0};
  localparam int ESPR   [NF] = '{0,120,200,110,790,50,51,100,120,200};
  localparam int REV    [NF] = '{0,0,0,0,0,0,0,0,0,1};
  localparam string REQ [NF] = '{"R4","R2","R3","R5","R6","R4","R4","R2","R2","R1"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, start = 1'b0, last = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [MW-1:0] mv = '0, tol = '0, sht = '0, opn = '0;
  logic done, pass;
  logic [IW-1:0] first;
  logic [MW-1:0] spread;
  logic [2*N-1:0] stat;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  vds_spread_checker #(.N_DOM(N), .MV_W(MW)) u_vds_spread_checker (
    .clk_i(clk), .rst_ni(rst_n),
    .sample_valid_i(valid), .sample_start_i(start), .sample_last_i(last),
    .sample_idx_i(idx), .sample_mv_i(mv),
    .tol_mv_i(tol), .short_mv_i(sht), .open_mv_i(opn),
    .done_o(done), .board_pass_o(pass), .first_fail_o(first),
    .spread_mv_o(spread), .stat_o(stat)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input int f, input bit inject);
    logic [2*N-1:0] ev;
    int cnt;
    bit seen;
    for (int d = 0; d < N; d++) ev[2*d +: 2] = 2'(EXP[f][d]);
    @(negedge clk);
    tol = MW'(TOL[f]); sht = MW'(SHT[f]); opn = MW'(OPN[f]);
    for (int k = 0; k < N; k++) begin
      int d;
      d = (REV[f] != 0) ? N - 1 - k : k;
      @(negedge clk);
      valid = 1'b1; start = (k == 0); last = (k == N - 1);
      idx = IW'(d); mv = MW'(VMV[f][d]);
    end
    cnt = 0;
    seen = 1'b0;
    while (!seen && cnt < 4 * N) begin
      @(negedge clk);
      cnt++;
      if (done) seen = 1'b1;
      if (inject && cnt <= 3) begin
        // R11: traffic during the scan
        valid = 1'b1; start = 1'b1; last = (cnt == 3); idx = 3'd2; mv = 12'd100;
      end else begin
        valid = 1'b0; start = 1'b0; last = 1'b0;
      end
    end
    // R10: first seen at the (N+1)th negedge after driving last
    chk(cnt == N + 1, inject ? "R11" : "R10", "done latency", cnt, N + 1);
    chk(stat == ev, REQ[f], "status vector", stat, ev);
    chk(pass == EPASS[f][0], "R7", "board pass", pass, EPASS[f]);
    if (EPASS[f] == 0)
      chk(int'(first) == EFIRST[f], "R8", "first fail", first, EFIRST[f]);
    chk(int'(spread) == ESPR[f], "R9", "spread", spread, ESPR[f]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset values, during and after reset
    chk(done == 1'b0 && pass == 1'b0, "R12", "done/pass in reset", {done, pass}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(stat == '0, "R12", "status after reset", stat, 0);
    chk(spread == '0 && first == '0, "R12", "spread/first after reset", {spread, first}, 0);
    chk(done == 1'b0, "R12", "done after reset", done, 0);

    for (int f = 0; f < NF; f++) run_frame(f, 1'b0);

    // R11: frame B with start samples injected mid-scan
    run_frame(1, 1'b1);

    // R1: non-start samples after done are ignored and done holds (R10)
    @(negedge clk);
    valid = 1'b1; start = 1'b0; last = 1'b1; idx = 3'd0; mv = 12'd0;
    repeat (3) @(negedge clk);
    valid = 1'b0; last = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R10", "done holds without start", done, 1);
    chk(stat == 12'h0dc, "R1", "status kept after stray samples", stat, 12'h0dc);
    chk(int'(spread) == 120, "R1", "spread kept after stray samples", spread, 120);

    // R10: an accepted start sample clears done and the results
    valid = 1'b1; start = 1'b1; last = 1'b0; idx = 3'd0; mv = 12'd360;
    @(negedge clk);
    valid = 1'b0; start = 1'b0;
    chk(done == 1'b0, "R10", "done cleared by start", done, 0);
    chk(stat == '0, "R10", "status cleared by start", stat, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule